// File: doc/BRIEF.md
# SCB Interrupt Status and Control

This block is the interrupt front end of a network controller's system control block. It keeps an eight-bit status byte and an eight-bit control byte, and it drives one level-sensitive interrupt request to the host. The command engine and the receive engine are outside the block. They reach it only as single-cycle event pulses, and each pulse latches one status bit. The host clears status bits by writing ones to them. It also writes the control byte, which holds a global mask, a software interrupt request and per-source masks.

The output is decided by a fixed priority. The global mask overrides everything else. Next, the software request forces the line high. Failing both, the line follows the four upper status bits, each gated by its own mask bit. The lower status bits are latched and can be read, but they never raise the line. The decision is registered, so the interrupt output follows the status and control bytes one cycle later.

Top module: `scb_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `status_o` is 0x00, `ctl_o` is 0x00 and `irq_o` is 0.
- R2: An `event_i` pulse on bit 7, 6, 5, 4, 3 or 0 sets the matching bit of `status_o` after that edge. The bit stays set until it is cleared.
- R3: `event_i` bits 2 and 1 have no effect on `status_o`. Status bit 1 always reads 0.
- R4: When `ack_we` is high, each `status_o` bit whose `ack_data` bit is 1 is cleared after the edge. Bits written with 0 keep their value.
- R5: If a bit is set and cleared in the same cycle, it ends up set.
- R6: When `ctl_we` is high, `ctl_data` is stored and appears on `ctl_o` after the edge. Control bit 0 is the global mask, bit 1 is the software request, and bits 7..4 mask status bits 7..4 one for one.
- R7: A control write with bit 1 set also sets status bit 2 at the same edge.
- R8: When control bit 0 is set, `irq_o` goes to 0 on the next edge, whatever the status and the software request hold.
- R9: When control bit 0 is clear and bit 1 is set, `irq_o` goes to 1 on the next edge, whatever the status and the source masks hold.
- R10: Otherwise `irq_o` is 1 exactly when some status bit among 7..4 is set and its control mask bit is clear. Status bits 3..0 never raise it.
- R11: `irq_o` is registered. It reflects the status and control bytes as they stood one edge earlier, so an event reaches `irq_o` two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 8 | Single-cycle event pulses, one per status bit position |
| ack_we | input | 1 | Host write strobe for status write-one-to-clear |
| ack_data | input | 8 | Ones mark the status bits to clear |
| ctl_we | input | 1 | Host write strobe for the control byte |
| ctl_data | input | 8 | New control byte |
| status_o | output | 8 | Current status byte |
| ctl_o | output | 8 | Current control byte |
| irq_o | output | 1 | Level interrupt request to the host |

## Verification
The checker watches these properties on every cycle:
- the three-level priority of the output, comparing `irq_o` against the control and status values of the cycle before;
- that an event beats a clear on the same bit;
- that the unimplemented status bit never rises.

Some behaviour only the directed scenarios can show:
- that each event position lands in the right status bit;
- that a partial clear spares the bits written with zero;
- that a software request shows up in status bit 2;
- that the output takes exactly two edges to follow an event.

// File: rtl/scb_irq_pkg.sv
package scb_irq_pkg;

    localparam int BYTE_W      = 8;
    localparam int SRC_LO      = 4;                 // lowest maskable status bit
    localparam int SRC_N       = BYTE_W - SRC_LO;   // number of maskable sources
    localparam int SWI_STAT    = 2;                 // status bit mirrored by software request
    localparam logic [BYTE_W-1:0] EVT_ACCEPT = 8'b1111_1001;
    localparam logic [BYTE_W-1:0] STAT_IMPL  = EVT_ACCEPT | (8'b1 << SWI_STAT);

    typedef struct packed {
        logic [SRC_N-1:0] src_mask;   // bits 7..4
        logic [1:0]       aux_mask;   // bits 3..2, stored only
        logic             swi;        // bit 1
        logic             gmask;      // bit 0
    } ctl_t;

    typedef enum logic [1:0] {
        ARB_MASKED = 2'd0,
        ARB_SOFT   = 2'd1,
        ARB_HW     = 2'd2
    } arb_sel_e;

    function automatic arb_sel_e arb_select(input logic gmask, input logic swi);
        if (gmask)    return ARB_MASKED;
        else if (swi) return ARB_SOFT;
        else          return ARB_HW;
    endfunction

    function automatic logic hw_pending(input logic [BYTE_W-1:0] st,
                                        input logic [SRC_N-1:0] msk);
        return |(st[BYTE_W-1:SRC_LO] & ~msk);
    endfunction

endpackage

// File: rtl/scb_stat_reg.sv
module scb_stat_reg
    import scb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] set_vec,
    input  logic [BYTE_W-1:0] clr_vec,
    output logic [BYTE_W-1:0] stat_o
);
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        if (STAT_IMPL[b]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)             bit_q <= 1'b0;
                else if (set_vec[b]) bit_q <= 1'b1;
                else if (clr_vec[b]) bit_q <= 1'b0;
            end
            assign stat_o[b] = bit_q;
        end else begin : g_tied
            assign stat_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/scb_ctl_reg.sv
module scb_ctl_reg
    import scb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output ctl_t              ctl_o,
    output logic              swi_set_o
);
    ctl_t ctl_q;
    ctl_t wr_view;

    assign wr_view = ctl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst)     ctl_q <= '0;
        else if (we) ctl_q <= wr_view;
    end

    assign ctl_o     = ctl_q;
    assign swi_set_o = we & wr_view.swi;
endmodule

// File: rtl/scb_irq_arb.sv
module scb_irq_arb
    import scb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [BYTE_W-1:0] stat,
    output logic              irq_o
);
    arb_sel_e sel;
    logic     irq_d;
    logic     irq_q;

    always_comb begin
        sel = arb_select(ctl.gmask, ctl.swi);
        unique case (sel)
            ARB_MASKED: irq_d = 1'b0;
            ARB_SOFT:   irq_d = 1'b1;
            ARB_HW:     irq_d = hw_pending(stat, ctl.src_mask);
            default:    irq_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/scb_irq_ctrl.sv
module scb_irq_ctrl
    import scb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] event_i,
    input  logic              ack_we,
    input  logic [BYTE_W-1:0] ack_data,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] ctl_data,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] ctl_o,
    output logic              irq_o
);
    ctl_t              ctl_w;
    logic              swi_set;
    logic [BYTE_W-1:0] set_vec;
    logic [BYTE_W-1:0] clr_vec;
    logic [BYTE_W-1:0] stat_w;

    scb_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .we        (ctl_we),
        .wdata     (ctl_data),
        .ctl_o     (ctl_w),
        .swi_set_o (swi_set)
    );

    assign set_vec = (event_i & EVT_ACCEPT) | ({{(BYTE_W-1){1'b0}}, swi_set} << SWI_STAT);
    assign clr_vec = ack_we ? ack_data : '0;

    scb_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_o  (stat_w)
    );

    scb_irq_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_w),
        .stat  (stat_w),
        .irq_o (irq_o)
    );

    assign status_o = stat_w;
    assign ctl_o    = ctl_w;
endmodule

// File: rtl/scb_irq_ctrl_chk.sv
module scb_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] event_i,
    input logic       ack_we,
    input logic [7:0] ack_data,
    input logic [7:0] status_o,
    input logic [7:0] ctl_o,
    input logic       irq_o
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    p_reset_clear_r1: assert property (@(posedge clk)
        past_ok && $past(rst) |-> (status_o == 8'h00 && ctl_o == 8'h00 && !irq_o));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        event_i[7] |=> status_o[7]);

    p_bit1_zero_r3: assert property (@(posedge clk) disable iff (rst)
        status_o[1] == 1'b0);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_we && ack_data[6] && !event_i[6]) |=> !status_o[6]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_we && ack_data[0] && event_i[0]) |=> status_o[0]);

    p_gmask_r8: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctl_o[0]) && !$past(rst) |-> !irq_o);

    p_soft_r9: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctl_o[1:0] == 2'b10) && !$past(rst) |-> irq_o);

    p_hw_r10: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctl_o[1:0] == 2'b00) && !$past(rst)
        |-> irq_o == |($past(status_o[7:4]) & ~$past(ctl_o[7:4])));
endmodule

bind scb_irq_ctrl scb_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .event_i  (event_i),
    .ack_we   (ack_we),
    .ack_data (ack_data),
    .status_o (status_o),
    .ctl_o    (ctl_o),
    .irq_o    (irq_o)
);

// File: tb/scb_irq_ctrl_bench.sv
module scb_irq_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] event_i = '0;
    logic       ack_we = 1'b0;
    logic [7:0] ack_data = '0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_data = '0;
    logic [7:0] status_o;
    logic [7:0] ctl_o;
    logic       irq_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scb_irq_ctrl u_scb_irq_ctrl (
        .clk(clk), .rst(rst), .event_i(event_i), .ack_we(ack_we), .ack_data(ack_data),
        .ctl_we(ctl_we), .ctl_data(ctl_data), .status_o(status_o), .ctl_o(ctl_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; returns at the negedge after the sampling edge.
    task automatic drive(input logic [7:0] ev, input logic aw, input logic [7:0] ad,
                         input logic cw, input logic [7:0] cd);
        event_i = ev; ack_we = aw; ack_data = ad; ctl_we = cw; ctl_data = cd;
        @(negedge clk);
        event_i = '0; ack_we = 1'b0; ack_data = '0; ctl_we = 1'b0; ctl_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic cleanup();
        drive(8'h00, 1'b1, 8'hFF, 1'b1, 8'h00);
        idle();
    endtask

    task automatic t_reset();
        drive(8'hFF, 1'b0, 8'h00, 1'b1, 8'hF2);
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        check("R1 status", status_o, 8'h00);
        check("R1 ctl", ctl_o, 8'h00);
        check("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_set_each();
        logic [7:0] acc = 8'h00;
        int pos [6] = '{7, 6, 5, 4, 3, 0};
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'hF0);   // mask all sources
        foreach (pos[i]) begin
            acc[pos[i]] = 1'b1;
            drive(8'h01 << pos[i], 1'b0, 8'h00, 1'b0, 8'h00);
            check("R2 set", status_o, acc);
        end
        idle();
        check("R2 hold", status_o, 8'hF9);
        cleanup();
    endtask

    task automatic t_ignored();
        drive(8'h06, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R3 status", status_o, 8'h00);
        idle();
        check("R3 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_w1c();
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'hF0);
        drive(8'hF9, 1'b0, 8'h00, 1'b0, 8'h00);
        drive(8'h00, 1'b1, 8'h90, 1'b0, 8'h00);
        check("R4 partial", status_o, 8'h69);
        drive(8'h00, 1'b1, 8'h69, 1'b0, 8'h00);
        check("R4 full", status_o, 8'h00);
        cleanup();
    endtask

    task automatic t_set_wins();
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'hF0);
        drive(8'h40, 1'b0, 8'h00, 1'b0, 8'h00);
        drive(8'h60, 1'b1, 8'hFF, 1'b0, 8'h00);
        check("R5 set over clear", status_o, 8'h60);
        cleanup();
    endtask

    task automatic t_ctl_write();
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'hAC);
        check("R6 ctl", ctl_o, 8'hAC);
        check("R6 status untouched", status_o, 8'h00);
        cleanup();
    endtask

    task automatic t_swi();
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'hF2);
        check("R7 status bit2", status_o, 8'h04);
        idle();
        check("R9 soft irq", {7'b0, irq_o}, 8'h01);
        drive(8'h00, 1'b1, 8'h04, 1'b1, 8'h00);
        idle();
        check("R9 soft released", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_gmask();
        drive(8'hF0, 1'b0, 8'h00, 1'b1, 8'h03);
        idle();
        check("R8 mask over soft", {7'b0, irq_o}, 8'h00);
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'h01);
        idle();
        check("R8 mask over hw", {7'b0, irq_o}, 8'h00);
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'h00);
        idle();
        check("R10 unmasked", {7'b0, irq_o}, 8'h01);
        cleanup();
    endtask

    task automatic t_hw_mask();
        drive(8'h00, 1'b0, 8'h00, 1'b1, 8'h80);
        drive(8'h80, 1'b0, 8'h00, 1'b0, 8'h00);
        idle();
        check("R10 masked source", {7'b0, irq_o}, 8'h00);
        drive(8'h40, 1'b0, 8'h00, 1'b0, 8'h00);
        idle();
        check("R10 other source", {7'b0, irq_o}, 8'h01);
        drive(8'h00, 1'b1, 8'hFF, 1'b1, 8'h00);
        drive(8'h09, 1'b0, 8'h00, 1'b0, 8'h00);
        idle();
        check("R10 low bits silent", {7'b0, irq_o}, 8'h00);
        cleanup();
    endtask

    task automatic t_latency();
        drive(8'h10, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R11 status first", status_o, 8'h10);
        check("R11 irq not yet", {7'b0, irq_o}, 8'h00);
        idle();
        check("R11 irq second edge", {7'b0, irq_o}, 8'h01);
        cleanup();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_each();
        t_ignored();
        t_w1c();
        t_set_wins();
        t_ctl_write();
        t_swi();
        t_gmask();
        t_hw_mask();
        t_latency();
        finish_run();
    end
endmodule